// File: doc/BRIEF.md
# Frame-Clock Ratio Detector

This block works out how fast the serial bit clock runs compared with the 8 kHz frame strobe that comes with it. The whole block runs on the bit clock. The frame strobe is sampled as an ordinary data input. A counter measures how many bit-clock cycles lie between two successive rising edges of the strobe.

After each reset the block takes one measurement. It ignores the partial frame that follows reset and uses the first complete frame. It matches that count against eight legal clock rates, which run from 32 to 1024 cycles per frame. From the match it latches a 3-bit rate code and the integer multiplier that a downstream clock synthesizer needs to reach 2048 cycles per frame (16.384 MHz). Both values then stay fixed until the next reset.

A count that matches no legal value raises a sticky error. So does a rate that is not allowed in the two-wire digital interface mode. In either case the code and multiplier keep their reset value of zero. A fixed number of cycles after the measurement is latched, a ready flag rises to say the synthesizer has had time to settle.

Top module: `frame_ratio_detect`

## Requirements
- R1: Reset is synchronous and active high. While reset is applied, and after its release until a measurement is latched, `rate_code`=0, `pll_mult`=0, `rate_err`=0, `code_valid`=0 and `ready`=0.
- R2: The measured count is the number of clock cycles between two successive rising edges of the sampled `fsync_in`. The width of the high pulse does not affect it. The counter saturates at 2^CNT_W-1.
- R3: The interval from reset release to the first rising edge is discarded. The latch uses the interval that ends at the second rising edge after reset, and `code_valid` goes to 1 a few cycles after that edge.
- R4: A count equal to BASE_RATIO times 1, 2, 3, 4, 6, 8, 16 or 32 latches `rate_code` 0, 1, 2, 3, 4, 5, 6 or 7 respectively.
- R5: For a count that is accepted, `pll_mult` equals floor(SYNTH_RATIO / count). With the default settings this runs from 64 down to 2.
- R6: A count that equals none of the eight legal values sets `rate_err`=1 and `code_valid`=1, and leaves `rate_code`=0 and `pll_mult`=0. A saturated count falls in this case.
- R7: When `gci_mode`=1 at the latching edge, a count that maps to code 2 or code 4 is rejected in the same way as in R6.
- R8: Once `code_valid`=1, `rate_code`, `pll_mult` and `rate_err` hold their values until reset, whatever later frames measure.
- R9: `ready` rises exactly SETTLE clock cycles after `code_valid` rises, and then stays high until reset. This happens whether or not an error was flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| fsync_in | input | 1 | Frame strobe, sampled on clk |
| gci_mode | input | 1 | 1 = two-wire digital interface mode, which excludes codes 2 and 4 |
| rate_code | output | 3 | Latched rate code, 0 = slowest |
| pll_mult | output | MULT_W | Latched synthesizer multiplier |
| rate_err | output | 1 | Sticky invalid-rate flag |
| code_valid | output | 1 | A measurement has been latched |
| ready | output | 1 | Settle delay after the latch has elapsed |

## Verification
The bench builds the block with BASE_RATIO=4, SYNTH_RATIO=256, CNT_W=8 and SETTLE=64. With these values the legal counts are 4 to 128, and an 8-bit counter saturates at 255.

The bench sweeps every frame period from 2 to 140 cycles in both interface modes. This covers every legal rate, every non-matching count in between and above, and both GCI exclusions. One more case uses a 300-cycle period to reach counter saturation.

Each case starts the strobe at an offset after reset and changes the period after the latch. It also times the ready delay. Together these exercise the discarded first interval, the hold after the latch and the settle count.

// File: rtl/frd_pkg.sv
package frd_pkg;
  localparam int NUM_RATES = 8;
  localparam int CODE_W    = 3;

  // Multiple of the slowest legal count for each rate code, ascending.
  function automatic int rate_step(input int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      4:       return 6;
      5:       return 8;
      6:       return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/frd_period_counter.sv
module frd_period_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync_in,
  output logic             frame_done,
  output logic [CNT_W-1:0] period
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fs_q, fs_prev, armed, rise;
  logic [CNT_W-1:0] cnt;

  assign rise = fs_q & ~fs_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q       <= 1'b0;
      fs_prev    <= 1'b0;
      cnt        <= '0;
      armed      <= 1'b0;
      frame_done <= 1'b0;
      period     <= '0;
    end else begin
      fs_q       <= fsync_in;
      fs_prev    <= fs_q;
      frame_done <= rise & armed;
      if (rise) begin
        cnt    <= CNT_W'(1);
        armed  <= 1'b1;
        period <= cnt;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cnt == CNT_W'(1)));
  // R3
  first_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && !armed) |=> !frame_done);
  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!rise && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/frd_rate_classifier.sv
module frd_rate_classifier
  import frd_pkg::*;
#(
  parameter int          CNT_W       = 11,
  parameter int          BASE_RATIO  = 32,
  parameter int          SYNTH_RATIO = 2048,
  parameter int          MULT_W      = 7,
  parameter logic [7:0]  GCI_EXCL    = 8'b0001_0100
) (
  input  logic [CNT_W-1:0]  period,
  input  logic              gci_mode,
  output logic [CODE_W-1:0] code,
  output logic [MULT_W-1:0] mult,
  output logic              bad
);
  logic [NUM_RATES-1:0] match;
  logic                 found;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_cmp
    assign match[g] = (period == CNT_W'(BASE_RATIO * rate_step(g)));
  end

  always_comb begin
    code  = '0;
    mult  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_RATES; i++) begin
      if (match[i]) begin
        code  = CODE_W'(i);
        mult  = MULT_W'(SYNTH_RATIO / (BASE_RATIO * rate_step(i)));
        found = 1'b1;
      end
    end
    bad = !found || (gci_mode && GCI_EXCL[code]);
  end

  // R4
  single_hit_chk: assert final ($onehot0(match));
endmodule

// File: rtl/frd_settle_timer.sv
module frd_settle_timer #(
  parameter int SETTLE = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready
);
  localparam int SC_W = $clog2(SETTLE + 1);

  logic [SC_W-1:0] sc;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc    <= '0;
      ready <= 1'b0;
    end else if (start && !ready) begin
      sc <= sc + 1'b1;
      if (sc == SC_W'(SETTLE - 1)) ready <= 1'b1;
    end
  end

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  // R9
  ready_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    !start |-> !ready);
endmodule

// File: rtl/frame_ratio_detect.sv
module frame_ratio_detect
  import frd_pkg::*;
#(
  parameter int  BASE_RATIO  = 32,
  parameter int  SYNTH_RATIO = 2048,
  parameter int  CNT_W       = 11,
  parameter int  SETTLE      = 64,
  localparam int MULT_W      = $clog2(SYNTH_RATIO / BASE_RATIO + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync_in,
  input  logic              gci_mode,
  output logic [2:0]        rate_code,
  output logic [MULT_W-1:0] pll_mult,
  output logic              rate_err,
  output logic              code_valid,
  output logic              ready
);
  logic             frame_done, cls_bad;
  logic [CNT_W-1:0] period;
  logic [2:0]       cls_code;
  logic [MULT_W-1:0] cls_mult;

  frd_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .fsync_in(fsync_in),
    .frame_done(frame_done), .period(period)
  );

  frd_rate_classifier #(
    .CNT_W(CNT_W), .BASE_RATIO(BASE_RATIO),
    .SYNTH_RATIO(SYNTH_RATIO), .MULT_W(MULT_W)
  ) u_cls (
    .period(period), .gci_mode(gci_mode),
    .code(cls_code), .mult(cls_mult), .bad(cls_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_code  <= '0;
      pll_mult   <= '0;
      rate_err   <= 1'b0;
      code_valid <= 1'b0;
    end else if (frame_done && !code_valid) begin
      code_valid <= 1'b1;
      if (cls_bad) begin
        rate_err <= 1'b1;
      end else begin
        rate_code <= cls_code;
        pll_mult  <= cls_mult;
      end
    end
  end

  frd_settle_timer #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst(rst), .start(code_valid), .ready(ready)
  );

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    code_valid |=> ($stable(rate_code) && $stable(pll_mult) && $stable(rate_err) && code_valid));
  // R6
  err_clears_code_chk: assert property (@(posedge clk) disable iff (rst)
    rate_err |-> (rate_code == '0 && pll_mult == '0 && code_valid));
  // R5
  mult_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (code_valid && !rate_err) |-> (pll_mult != '0));
  // R9
  ready_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> code_valid);
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !code_valid |-> (rate_code == '0 && pll_mult == '0 && !rate_err));
endmodule

// File: tb/sim_frame_ratio_detect.sv
`timescale 1ns/1ps
module sim_frame_ratio_detect;
  localparam int BASE = 4, SYN = 256, CW = 8, ST = 64, MW = 7;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst = 1, fsync_in = 0, gci_mode = 0;
  logic [2:0] rate_code;
  logic [MW-1:0] pll_mult;
  logic rate_err, code_valid, ready;

  frame_ratio_detect #(.BASE_RATIO(BASE), .SYNTH_RATIO(SYN), .CNT_W(CW), .SETTLE(ST)) u0 (
    .clk(clk), .rst(rst), .fsync_in(fsync_in), .gci_mode(gci_mode),
    .rate_code(rate_code), .pll_mult(pll_mult), .rate_err(rate_err),
    .code_valid(code_valid), .ready(ready));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, gap = -1, kcnt = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // Ready delay monitor (R9)
  always @(negedge clk) begin
    if (rst) begin gap = -1; kcnt = 0; end
    else begin
      if (code_valid && !ready) kcnt++;
      if (ready && gap < 0) gap = kcnt;
    end
  end

  function automatic int step_of(int i);
    int t[8] = '{1, 2, 3, 4, 6, 8, 16, 32};
    return t[i];
  endfunction

  task automatic chk(string req, int got, int exp, int p, int g);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s P=%0d gci=%0d got %0d expected %0d", req, p, g, got, exp);
    end
  endtask

  task automatic cyc1();
    @(posedge clk); #1;
  endtask

  task automatic frames(int p, int n);
    int w = (p >= 3) ? 2 : 1;
    for (int f = 0; f < n; f++)
      for (int i = 0; i < p; i++) begin
        fsync_in = (i < w);
        cyc1();
      end
  endtask

  task automatic run_case(int p, int g);
    int eff, ecode, emult, eerr, idx;
    rst = 1; fsync_in = 0; gci_mode = g[0];
    cyc1(); cyc1();
    rst = 0;
    @(negedge clk);
    chk("R1 reset code", rate_code, 0, p, g);
    chk("R1 reset flags", {rate_err, code_valid, ready, (pll_mult != 0)}, 0, p, g);
    cyc1(); cyc1(); cyc1();      // R3: partial interval before the first edge
    frames(p, 2);                // edges 1 and 2: latch on the second
    frames(p + 5, 2);            // R8: different later periods
    fsync_in = 0;
    repeat (ST + 8) cyc1();
    @(negedge clk);
    eff = (p > CMAX) ? CMAX : p;
    idx = -1;
    for (int i = 0; i < 8; i++) if (eff == BASE * step_of(i)) idx = i;
    eerr = (idx < 0) || (g == 1 && (idx == 2 || idx == 4));
    ecode = eerr ? 0 : idx;
    emult = eerr ? 0 : SYN / eff;
    chk("R4/R8 code", rate_code, ecode, p, g);
    chk("R5 mult", pll_mult, emult, p, g);
    chk(g ? "R7/R6 err" : "R6 err", rate_err, eerr, p, g);
    chk("R3 valid", code_valid, 1, p, g);
    chk("R9 settle gap", gap, ST, p, g);
  endtask

  initial begin
    for (int g = 0; g < 2; g++)
      for (int p = 2; p <= 140; p++) run_case(p, g);
    run_case(300, 0);            // R2/R6 saturated counter
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule